// File: doc/BRIEF.md
# Windowed Bank Address Mapper

This block sits between a 16-bit coprocessor and a shared RAM that is larger than the coprocessor can reach directly. The 1 MB logical space is cut into sixteen windows of 64 KB. The top four logical address bits pick a window. Each window has its own 5-bit bank number, and that number becomes the upper bits of a 21-bit physical address. The low sixteen logical bits pass through unchanged, so every window can show any 64 KB slice of a 2 MB RAM.

Firmware sets the bank numbers by writing to a small register file in I/O space. There is one 16-bit register per window, laid out as consecutive words, and the word offset selects the window. Translation is purely combinational. A new bank number applies to accesses from the cycle after the write. After reset, every window points at the topmost bank. The boot code placed in that bank therefore appears at every logical address, including the vector area.

Top module: `bankmap_window_mapper`

## Requirements
- R1: After reset every window holds bank 0x1F, so `phys_addr` equals 0x1F0000 plus `log_addr[15:0]` for any logical address.
- R2: `log_addr[19:16]` selects which window's bank number is used for translation.
- R3: `phys_addr[20:16]` is the selected bank number and `phys_addr[15:0]` equals `log_addr[15:0]`, in the same cycle with no register in the path.
- R4: A write with `io_wr_en` high and `io_addr` in 0x200..0x21F loads window `io_addr[4:1]`; `io_addr[0]` has no effect on the selection.
- R5: Only `io_wdata[4:0]` is stored; `io_wdata[15:5]` is discarded.
- R6: A write with `io_addr` below 0x200 or above 0x21F leaves every bank number unchanged.
- R7: With `io_rd_en` high and `io_addr` in 0x200..0x21F, `io_rdata` returns the 5-bit bank of window `io_addr[4:1]` zero-extended to 16 bits; otherwise `io_rdata` is 0.
- R8: A bank write changes translation and read-back starting on the cycle after the write edge; in the cycle of the write the old value is still seen.
- R9: A write to one window leaves the other fifteen windows unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| io_wr_en | input | 1 | I/O write strobe |
| io_rd_en | input | 1 | I/O read strobe |
| io_addr | input | 16 | I/O byte address |
| io_wdata | input | 16 | I/O write data |
| io_rdata | output | 16 | I/O read data, zero-extended bank number or 0 |
| log_addr | input | 20 | Coprocessor logical address |
| phys_addr | output | 21 | Physical RAM address |

## Verification
All state lives in the sixteen bank numbers, and each one is visible at the ports in two ways: through `io_rdata` and through `phys_addr[20:16]` when `log_addr` falls in that window. A wrong bank value, a misdecoded window or a stray write therefore shows up in the first cycle after the faulty edge, once either path touches the affected window. The bench compares both outputs against a behavioural model in every cycle. It also sweeps all windows after each group of writes, so a corruption that lands in an unrelated window is not missed.

// File: rtl/bankmap_pkg.sv
package bankmap_pkg;
  localparam int LOG_AW   = 20;               // logical address width
  localparam int WIN_BITS = 4;                // window select width
  localparam int BANK_W   = 5;                // bank number width
  localparam int IO_AW    = 16;
  localparam int IO_DW    = 16;
  localparam logic [15:0] IO_BASE = 16'h0200; // aligned to the register span
  localparam int NUM_WIN  = 1 << WIN_BITS;
  localparam int OFF_BITS = LOG_AW - WIN_BITS;
  localparam int PHYS_AW  = OFF_BITS + BANK_W;
  typedef logic [BANK_W-1:0] bank_t;
endpackage

// File: rtl/bankmap_rst_sync.sv
module bankmap_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] stage_q;
  logic [1:0] stage_d;

  always_comb stage_d = {stage_q[0], 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= stage_d;
  end

  assign rst_sync_n = stage_q[1];
endmodule

// File: rtl/bankmap_io_decode.sv
module bankmap_io_decode #(
  parameter int          IO_AW    = bankmap_pkg::IO_AW,
  parameter int          WIN_BITS = bankmap_pkg::WIN_BITS,
  parameter logic [15:0] IO_BASE  = bankmap_pkg::IO_BASE
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [IO_AW-1:0]      addr,
  output logic                  hit,
  output logic [WIN_BITS-1:0]   sel,
  output logic [(1<<WIN_BITS)-1:0] wr_onehot
);
  localparam int NUM_WIN = 1 << WIN_BITS;
  localparam int SPAN    = NUM_WIN * 2;   // bytes: one 16-bit word per window
  localparam logic [IO_AW:0] LO_LIM = {1'b0, IO_BASE[IO_AW-1:0]};
  localparam logic [IO_AW:0] HI_LIM = LO_LIM + SPAN[IO_AW:0];

  always_comb begin
    hit = ({1'b0, addr} >= LO_LIM) && ({1'b0, addr} < HI_LIM);
    sel = addr[WIN_BITS:1];
  end

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_strobe
    assign wr_onehot[w] = wr_en && hit && (sel == w[WIN_BITS-1:0]);
  end

  assert_outside_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!hit) |-> (wr_onehot == '0));
  assert_single_window_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_onehot));
endmodule

// File: rtl/bankmap_bank_regs.sv
module bankmap_bank_regs #(
  parameter int          WIN_BITS = bankmap_pkg::WIN_BITS,
  parameter int          BANK_W   = bankmap_pkg::BANK_W,
  parameter int          IO_DW    = bankmap_pkg::IO_DW,
  parameter logic [BANK_W-1:0] RESET_BANK = '1
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic [(1<<WIN_BITS)-1:0]          wr_onehot,
  input  logic [IO_DW-1:0]                  wdata,
  input  logic [WIN_BITS-1:0]               rd_sel,
  output logic [BANK_W-1:0]                 rd_bank,
  output logic [(1<<WIN_BITS)-1:0][BANK_W-1:0] banks
);
  localparam int NUM_WIN = 1 << WIN_BITS;

  logic [NUM_WIN-1:0][BANK_W-1:0] bank_q;
  logic [NUM_WIN-1:0][BANK_W-1:0] bank_d;
  logic [NUM_WIN-1:0]             bank_en;

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    always_comb begin
      bank_en[w] = wr_onehot[w];
      bank_d[w]  = wdata[BANK_W-1:0];   // upper data bits are dropped
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)          bank_q[w] <= RESET_BANK;
      else if (bank_en[w]) bank_q[w] <= bank_d[w];
    end

    assert_win_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_onehot[w] |=> (bank_q[w] == $past(wdata[BANK_W-1:0])));
    assert_win_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_onehot[w]) |=> $stable(bank_q[w]));
  end

  always_comb begin
    rd_bank = bank_q[rd_sel];
    banks   = bank_q;
  end
endmodule

// File: rtl/bankmap_xlate.sv
module bankmap_xlate #(
  parameter int LOG_AW   = bankmap_pkg::LOG_AW,
  parameter int WIN_BITS = bankmap_pkg::WIN_BITS,
  parameter int BANK_W   = bankmap_pkg::BANK_W
) (
  input  logic                                 clk,
  input  logic                                 rst_n,
  input  logic [LOG_AW-1:0]                    log_addr,
  input  logic [(1<<WIN_BITS)-1:0][BANK_W-1:0] banks,
  output logic [LOG_AW-WIN_BITS+BANK_W-1:0]    phys_addr
);
  localparam int OFF_BITS = LOG_AW - WIN_BITS;

  logic [WIN_BITS-1:0] win;
  logic [BANK_W-1:0]   sel_bank;

  always_comb begin
    win       = log_addr[LOG_AW-1:OFF_BITS];
    sel_bank  = banks[win];
    phys_addr = {sel_bank, log_addr[OFF_BITS-1:0]};
  end

  assert_offset_pass_R3: assert property (@(posedge clk) disable iff (!rst_n)
    phys_addr[OFF_BITS-1:0] == log_addr[OFF_BITS-1:0]);
endmodule

// File: rtl/bankmap_window_mapper.sv
module bankmap_window_mapper #(
  parameter int          LOG_AW   = bankmap_pkg::LOG_AW,
  parameter int          WIN_BITS = bankmap_pkg::WIN_BITS,
  parameter int          BANK_W   = bankmap_pkg::BANK_W,
  parameter int          IO_AW    = bankmap_pkg::IO_AW,
  parameter int          IO_DW    = bankmap_pkg::IO_DW,
  parameter logic [15:0] IO_BASE  = bankmap_pkg::IO_BASE
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             io_wr_en,
  input  logic                             io_rd_en,
  input  logic [IO_AW-1:0]                 io_addr,
  input  logic [IO_DW-1:0]                 io_wdata,
  output logic [IO_DW-1:0]                 io_rdata,
  input  logic [LOG_AW-1:0]                log_addr,
  output logic [LOG_AW-WIN_BITS+BANK_W-1:0] phys_addr
);
  localparam int NUM_WIN = 1 << WIN_BITS;

  logic                           rst_sync_n;
  logic                           hit;
  logic [WIN_BITS-1:0]            sel;
  logic [NUM_WIN-1:0]             wr_onehot;
  logic [BANK_W-1:0]              rd_bank;
  logic [NUM_WIN-1:0][BANK_W-1:0] banks;

  bankmap_rst_sync i_rst_sync (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  bankmap_io_decode #(.IO_AW(IO_AW), .WIN_BITS(WIN_BITS), .IO_BASE(IO_BASE)) i_decode (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(io_wr_en), .addr(io_addr),
    .hit(hit), .sel(sel), .wr_onehot(wr_onehot)
  );

  bankmap_bank_regs #(.WIN_BITS(WIN_BITS), .BANK_W(BANK_W), .IO_DW(IO_DW)) i_regs (
    .clk(clk), .rst_n(rst_sync_n), .wr_onehot(wr_onehot), .wdata(io_wdata),
    .rd_sel(sel), .rd_bank(rd_bank), .banks(banks)
  );

  bankmap_xlate #(.LOG_AW(LOG_AW), .WIN_BITS(WIN_BITS), .BANK_W(BANK_W)) i_xlate (
    .clk(clk), .rst_n(rst_sync_n), .log_addr(log_addr), .banks(banks),
    .phys_addr(phys_addr)
  );

  always_comb begin
    io_rdata = '0;
    if (io_rd_en && hit) io_rdata[BANK_W-1:0] = rd_bank;
  end

  assert_rdata_zext_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    io_rdata[IO_DW-1:BANK_W] == '0);
  assert_rdata_idle_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (!io_rd_en) |-> (io_rdata == '0));
  assert_update_next_R8: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (io_wr_en && hit && $stable(log_addr) && log_addr[LOG_AW-1:LOG_AW-WIN_BITS] == sel)
      |=> (phys_addr[LOG_AW-WIN_BITS+BANK_W-1:LOG_AW-WIN_BITS] == $past(io_wdata[BANK_W-1:0])));
endmodule

// File: tb/test_bankmap_window_mapper.sv
module test_bankmap_window_mapper;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        io_wr_en, io_rd_en;
  logic [15:0] io_addr, io_wdata, io_rdata;
  logic [19:0] log_addr;
  logic [20:0] phys_addr;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  int model [16];

  always #(CLK_PERIOD/2) clk = ~clk;

  bankmap_window_mapper i_bankmap_window_mapper (
    .clk(clk), .rst_n(rst_n), .io_wr_en(io_wr_en), .io_rd_en(io_rd_en),
    .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
    .log_addr(log_addr), .phys_addr(phys_addr)
  );

  function automatic bit in_range(input int a);
    return (a >= 'h200) && (a <= 'h21F);
  endfunction

  // one clock: apply inputs after a falling edge, compare, then let the rising edge act
  task automatic cyc(input string tag, input bit wr, input bit rd, input int a,
                     input int wd, input int la);
    int exp_phys, exp_rd;
    io_wr_en = wr; io_rd_en = rd; io_addr = a[15:0]; io_wdata = wd[15:0];
    log_addr = la[19:0];
    #1;
    exp_phys = model[(la >> 16) & 15] * 'h10000 + (la & 'hFFFF);
    exp_rd   = (rd && in_range(a)) ? model[((a - 'h200) / 2) & 15] : 0;
    checks++;
    if (int'(phys_addr) != exp_phys) begin
      fails++;
      $display("FAIL %s phys_addr actual=%h expected=%h", tag, phys_addr, exp_phys);
    end
    checks++;
    if (int'(io_rdata) != exp_rd) begin
      fails++;
      $display("FAIL %s io_rdata actual=%h expected=%h", tag, io_rdata, exp_rd);
    end
    @(posedge clk);
    if (wr && in_range(a) && rst_n) model[((a - 'h200) / 2) & 15] = wd % 32;
    @(negedge clk);
  endtask

  // read back every window and translate one address in each
  task automatic sweep(input string tag);
    for (int w = 0; w < 16; w++) cyc(tag, 0, 1, 'h200 + 2*w, 0, w*'h10000 + 'h1234 + w);
  endtask

  initial begin
    for (int w = 0; w < 16; w++) model[w] = 'h1F;
    rst_n = 1'b0;
    io_wr_en = 0; io_rd_en = 0; io_addr = 0; io_wdata = 0; log_addr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    // R1 reset state: every window maps to the top bank
    cyc("R1", 0, 0, 0, 0, 'h00000);
    cyc("R1", 0, 0, 0, 0, 'hFFFFF);
    cyc("R1", 0, 0, 0, 0, 'h7ABCD);
    sweep("R1");
    // R4 window load by word offset; R2/R3 translation selects it
    cyc("R4", 1, 0, 'h206, 'h0005, 'h30010);
    cyc("R2", 0, 0, 0, 0, 'h3FFFF);
    cyc("R3", 0, 0, 0, 0, 'h2FFFF);
    // R4 odd byte address selects same window
    cyc("R4", 1, 0, 'h209, 'h000A, 'h40000);
    cyc("R4", 0, 1, 'h208, 0, 'h4BEEF);
    // R5 upper data bits discarded
    cyc("R5", 1, 0, 'h200, 'hFFE2, 'h00000);
    cyc("R5", 0, 1, 'h200, 0, 'h0CAFE);
    // R6 writes just outside the range
    cyc("R6", 1, 0, 'h1FE, 'h0003, 'hF0000);
    cyc("R6", 1, 0, 'h220, 'h0004, 'hF0000);
    cyc("R6", 1, 0, 'h000, 'h0007, 'hF0000);
    sweep("R6");
    // R7 reads outside the range or without strobe return zero
    cyc("R7", 0, 1, 'h1FE, 0, 0);
    cyc("R7", 0, 1, 'h220, 0, 0);
    cyc("R7", 0, 0, 'h206, 0, 0);
    // R8 write to the window in use: old bank this cycle, new bank next cycle
    cyc("R8", 1, 1, 'h20A, 'h0011, 'h5AAAA);
    cyc("R8", 0, 1, 'h20A, 0, 'h5AAAA);
    cyc("R8", 1, 0, 'h21E, 'h0000, 'hF1111);
    cyc("R8", 0, 0, 0, 0, 'hF1111);
    // R9 distinct values in every window, then sweep
    for (int w = 0; w < 16; w++) cyc("R9", 1, 0, 'h200 + 2*w, 'h40 + 3*w, w*'h10000);
    sweep("R9");
    cyc("R9", 1, 0, 'h214, 'h001F, 'hA0000);
    sweep("R9");
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule